// File: doc/BRIEF.md
# I2C Slave Address Matcher with Masking

This block decides whether the address phase of an I2C transfer is meant for this target. It sits behind a bit-level receiver that has already turned SDA/SCL activity into whole bytes. The receiver raises `bus_start` for every start or repeated-start condition and then presents each received byte with a one-cycle `byte_vld` strobe. The matcher checks the first byte, and in 10-bit mode also the second, against the programmed own address. It reports an accepted address with a single-cycle `match_pulse`.

A five-bit mask lets the owner treat selected address bits as don't-care, so one target can answer a whole family of addresses. Mask bit 0 covers address bit 1 in 7-bit mode and both bits 1 and 0 in 10-bit mode. Separately, the all-zero general-call address can be accepted. The block also keeps an interrupt-request level and a general-call flag, and it captures the read/write bit of the first byte.

Bytes enter on a strobe-only stream. The block is always ready, so it applies no back-pressure. Every byte strobed outside a `bus_start` cycle is consumed in the cycle it appears, and the sender never waits.

Top module: `i2c_addr_filter`

## Requirements
- R1: In 7-bit mode (`mode_10b`=0), bits 7..1 of the first byte after `bus_start` form the address, and they are compared with `own_addr[6:0]`. When they agree, `match_pulse` is high for exactly one cycle, the cycle after that byte's strobe.
- R2: `rw_bit` takes bit 0 of the first byte in the cycle after that byte's strobe. It keeps that value until the next first byte arrives.
- R3: Setting `mask_bits[k]` for k = 1..4 makes address bit k+1 a don't-care, in both modes.
- R4: In 7-bit mode, `mask_bits[0]` makes address bit 1 a don't-care while address bit 0 is still compared.
- R5: In 10-bit mode, the first byte must equal `{5'b11110, own_addr[9:8], rw}`, and the header bits are never masked. The second byte is compared with `own_addr[7:0]`. `match_pulse` comes only in the cycle after the second byte, never after the first.
- R6: In 10-bit mode, `mask_bits[0]` makes both address bits 1 and 0 of the second byte don't-care.
- R7: With `mask_bits` all zero, every address bit is compared exactly.
- R8: With `gc_en`=1, a first byte of 8'h00 produces `match_pulse` in the cycle after it, in either mode. It also sets `gcall_flag` and `irq`.
- R9: With `gc_en`=0, a first byte of 8'h00 never produces `match_pulse`, `gcall_flag` or `irq`, whatever the own address and mask.
- R10: `irq` rises with every `match_pulse`. `irq` and `gcall_flag` stay high until the next `bus_start`, which clears them and also `match_pulse` in the following cycle. A byte strobed in the same cycle as `bus_start` is ignored.
- R11: Once a frame's address has been accepted or rejected, further bytes have no effect until the next `bus_start`.
- R12: After reset, `match_pulse`, `gcall_flag`, `irq` and `rw_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated start seen; rearms address decoding |
| byte_vld | input | 1 | Strobe: `byte_dat` holds a received byte |
| byte_dat | input | 8 | Received byte, MSB first as on the wire |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit addressing |
| own_addr | input | 10 | Own address (7-bit mode uses bits 6..0) |
| mask_bits | input | 5 | Don't-care mask; all zero = exact compare |
| gc_en | input | 1 | Accept the general-call address |
| match_pulse | output | 1 | One-cycle pulse: address accepted |
| gcall_flag | output | 1 | Accepted address was the general call |
| irq | output | 1 | Interrupt request, held until next `bus_start` |
| rw_bit | output | 1 | Read/write bit of the first byte |

## Verification
The hardest case is a 10-bit frame whose header matches and whose low byte differs from the own address only in bits 1 and 0. It must then match or fail depending only on mask bit 0. Random addresses almost never hit that case. The stimulus therefore takes the own address and flips one or two chosen bits, and it sweeps all 32 mask settings in both modes. Each frame goes to a reference built from a per-bit ignore rule. Separate directed frames cover a byte that coincides with `bus_start`, bytes that arrive after a decision, and the all-zero address with the general-call enable off while the own address is also zero.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;
  localparam int MASK_W   = 5;
  localparam int HDR_W    = 5;
  localparam logic [HDR_W-1:0] HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    SEQ_FIRST = 2'd0,
    SEQ_LOW   = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/amatch_care_gen.sv
module amatch_care_gen #(
  parameter int BYTE_W   = 8,
  parameter int MASK_W   = 5,
  parameter bit WIDE_LSB = 1'b0
) (
  input  logic [MASK_W-1:0] mask_bits,
  output logic [BYTE_W-1:0] care
);
  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
    if (gi == 0) begin : g_lsb
      if (WIDE_LSB) begin : g_pair
        assign care[gi] = ~mask_bits[0];
      end else begin : g_solo
        assign care[gi] = 1'b1;
      end
    end else if (gi == 1) begin : g_b1
      assign care[gi] = ~mask_bits[0];
    end else if (gi <= MASK_W) begin : g_mid
      assign care[gi] = ~mask_bits[gi-1];
    end else begin : g_top
      assign care[gi] = 1'b1;
    end
  end
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] care,
  output logic         eq
);
  logic [W-1:0] diff;
  always_comb diff = (a ^ b) & care;
  assign eq = ~|diff;
endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
  import i2c_amatch_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_start,
  input  logic                byte_vld,
  input  logic [BYTE_W-1:0]   byte_dat,
  input  logic                mode_10b,
  input  logic [ADDR10_W-1:0] own_addr,
  input  logic [MASK_W-1:0]   mask_bits,
  input  logic                gc_en,
  output logic                match_pulse,
  output logic                gcall_flag,
  output logic                irq,
  output logic                rw_bit
);
  localparam int HI_W = ADDR10_W - BYTE_W;

  logic [BYTE_W-1:0] care7, care10;
  logic eq7, eq_lo, hdr_ok, is_zero;
  seq_state_e state;

  amatch_care_gen #(.BYTE_W(BYTE_W), .MASK_W(MASK_W), .WIDE_LSB(1'b0)) u_care7 (
    .mask_bits(mask_bits), .care(care7));
  amatch_care_gen #(.BYTE_W(BYTE_W), .MASK_W(MASK_W), .WIDE_LSB(1'b1)) u_care10 (
    .mask_bits(mask_bits), .care(care10));

  amatch_cmp #(.W(ADDR7_W)) u_cmp7 (
    .a(byte_dat[BYTE_W-1:1]), .b(own_addr[ADDR7_W-1:0]),
    .care(care7[ADDR7_W-1:0]), .eq(eq7));
  amatch_cmp #(.W(BYTE_W)) u_cmp_lo (
    .a(byte_dat), .b(own_addr[BYTE_W-1:0]), .care(care10), .eq(eq_lo));

  assign hdr_ok  = (byte_dat[BYTE_W-1 -: HDR_W] == HDR10) &&
                   (byte_dat[HI_W:1] == own_addr[ADDR10_W-1:BYTE_W]);
  assign is_zero = (byte_dat == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_FIRST;
      match_pulse <= 1'b0;
      gcall_flag  <= 1'b0;
      irq         <= 1'b0;
      rw_bit      <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (bus_start) begin
        state      <= SEQ_FIRST;
        gcall_flag <= 1'b0;
        irq        <= 1'b0;
      end else if (byte_vld) begin
        unique case (state)
          SEQ_FIRST: begin
            rw_bit <= byte_dat[0];
            state  <= SEQ_HOLD;
            if (is_zero) begin
              if (gc_en) begin
                match_pulse <= 1'b1;
                gcall_flag  <= 1'b1;
                irq         <= 1'b1;
              end
            end else if (!mode_10b) begin
              if (eq7) begin
                match_pulse <= 1'b1;
                irq         <= 1'b1;
              end
            end else if (hdr_ok) begin
              state <= SEQ_LOW;
            end
          end
          SEQ_LOW: begin
            state <= SEQ_HOLD;
            if (eq_lo) begin
              match_pulse <= 1'b1;
              irq         <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/amatch_checker.sv
module amatch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start,
  input logic       byte_vld,
  input logic [7:0] byte_dat,
  input logic       mode_10b,
  input logic [9:0] own_addr,
  input logic [4:0] mask_bits,
  input logic       gc_en,
  input logic       match_pulse,
  input logic       gcall_flag,
  input logic       irq,
  input logic       rw_bit
);
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  p_pulse_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ($past(byte_vld) && !$past(bus_start)));

  p_rw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(rw_bit));

  p_exact_compare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !gcall_flag && !$past(mode_10b) && ($past(mask_bits) == 5'd0))
      |-> ($past(byte_dat[7:1]) == $past(own_addr[6:0])));

  p_gc_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_flag) |-> (match_pulse && $past(gc_en) && ($past(byte_dat) == 8'h00)));

  p_zero_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !gcall_flag && !$past(mode_10b)) |-> ($past(byte_dat) != 8'h00));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> match_pulse);

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (!irq && !gcall_flag && !match_pulse));
endmodule

bind i2c_addr_filter amatch_checker u_amatch_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .byte_vld(byte_vld),
  .byte_dat(byte_dat), .mode_10b(mode_10b), .own_addr(own_addr),
  .mask_bits(mask_bits), .gc_en(gc_en), .match_pulse(match_pulse),
  .gcall_flag(gcall_flag), .irq(irq), .rw_bit(rw_bit)
);

// File: tb/tb_i2c_addr_filter.sv
`timescale 1ns/1ps
module tb_i2c_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, byte_vld = 1'b0, mode_10b = 1'b0, gc_en = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [9:0] own_addr = '0;
  logic [4:0] mask_bits = '0;
  logic match_pulse, gcall_flag, irq, rw_bit;

  int n_chk = 0, n_bad = 0, exp_pulses = 0, seen_pulses = 0;
  bit done = 1'b0;

  typedef struct { bit m; bit g; bit rw; string tag; } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  always #2 clk = ~clk;

  i2c_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .mode_10b(mode_10b), .own_addr(own_addr),
    .mask_bits(mask_bits), .gc_en(gc_en), .match_pulse(match_pulse),
    .gcall_flag(gcall_flag), .irq(irq), .rw_bit(rw_bit));

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ignored(input int i, input bit m10, input logic [4:0] mk);
    if (i >= 2 && i <= 5) return mk[i-1];
    if (i == 1) return mk[0];
    if (i == 0) return m10 & mk[0];
    return 1'b0;
  endfunction

  function automatic bit ref_match(input bit m10, input logic [7:0] b0, input logic [7:0] b1,
                                   input logic [9:0] own, input logic [4:0] mk, input bit gce);
    if (b0 == 8'h00) return gce;
    if (!m10) begin
      for (int i = 0; i < 7; i++)
        if (!ignored(i, 1'b0, mk) && (b0[i+1] != own[i])) return 1'b0;
      return 1'b1;
    end
    if (b0[7:3] != 5'b11110 || b0[2:1] != own[9:8]) return 1'b0;
    for (int i = 0; i < 8; i++)
      if (!ignored(i, 1'b1, mk) && (b1[i] != own[i])) return 1'b0;
    return 1'b1;
  endfunction

  // driver: one frame, expectation pushed to the scoreboard
  task automatic run_frame(input bit m10, input logic [7:0] b0, input logic [7:0] b1,
                           input string tag);
    exp_t e;
    e.m = ref_match(m10, b0, b1, own_addr, mask_bits, gc_en);
    e.g = (b0 == 8'h00) && gc_en;
    e.rw = b0[0];
    e.tag = tag;
    mode_10b = m10;
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0; byte_vld = 1'b1; byte_dat = b0;
    if (m10 && b0 != 8'h00) begin
      @(negedge clk) byte_dat = b1;
    end
    @(negedge clk) byte_vld = 1'b0;
    if (e.m) exp_pulses++;
    sb_q.push_back(e);
    ->chk_ev;
    @(negedge clk);
  endtask

  // monitor: compare as the design produces results
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      e = sb_q.pop_front();
      check_eq({"R1/R5 match ", e.tag}, match_pulse, e.m);
      check_eq({"R8 gcall ", e.tag}, gcall_flag, e.g);
      check_eq({"R10 irq ", e.tag}, irq, e.m);
      check_eq({"R2 rw ", e.tag}, rw_bit, e.rw);
    end
  end

  always @(negedge clk) if (rst_n && match_pulse) seen_pulses++;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R12 reset match", match_pulse, 0);
    check_eq("R12 reset gcall", gcall_flag, 0);
    check_eq("R12 reset irq", irq, 0);
    check_eq("R12 reset rw", rw_bit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7: exact 7-bit compare
    own_addr = 10'h05A; mask_bits = 5'd0; gc_en = 1'b0;
    run_frame(0, {7'h5A, 1'b1}, 8'h00, "R1 exact hit");
    run_frame(0, {7'h5B, 1'b0}, 8'h00, "R7 bit0 differs");
    // R4: mask0 covers bit1 only in 7-bit mode
    mask_bits = 5'b00001;
    run_frame(0, {7'h58, 1'b0}, 8'h00, "R4 bit1 masked");
    run_frame(0, {7'h5B, 1'b0}, 8'h00, "R4 bit0 still compared");
    // R3
    mask_bits = 5'b10000;
    run_frame(0, {7'h7A, 1'b0}, 8'h00, "R3 bit5 masked");
    // R5 R6: 10-bit
    own_addr = 10'h2C4; mask_bits = 5'b00001;
    run_frame(1, {5'b11110, 2'b10, 1'b0}, 8'hC7, "R6 bits1..0 masked");
    run_frame(1, {5'b11110, 2'b11, 1'b0}, 8'hC4, "R5 header differs");
    mask_bits = 5'd0;
    run_frame(1, {5'b11110, 2'b10, 1'b1}, 8'hC5, "R5 low differs");
    // R8 R9: general call, own address zero
    own_addr = 10'h000;
    run_frame(0, 8'h00, 8'h00, "R9 zero gc off");
    gc_en = 1'b1;
    run_frame(0, 8'h00, 8'h00, "R8 zero gc on 7b");
    run_frame(1, 8'h00, 8'h00, "R8 zero gc on 10b");
    // R10: irq held, then cleared by bus_start
    repeat (3) @(negedge clk);
    check_eq("R10 irq held", irq, 1);
    bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
    check_eq("R10 irq cleared", irq, 0);
    check_eq("R10 gcall cleared", gcall_flag, 0);
    // R10: byte coinciding with bus_start ignored
    own_addr = 10'h031; gc_en = 1'b0; mode_10b = 1'b0;
    bus_start = 1'b1; byte_vld = 1'b1; byte_dat = {7'h31, 1'b0};
    @(negedge clk) bus_start = 1'b0; byte_vld = 1'b0;
    check_eq("R10 byte with start ignored", match_pulse, 0);
    byte_vld = 1'b1;
    @(negedge clk) byte_vld = 1'b0;
    check_eq("R10 next byte decoded", match_pulse, 1);
    exp_pulses++;
    // R11: bytes after a decision ignored
    run_frame(0, {7'h30, 1'b0}, 8'h00, "R11 miss frame");
    byte_vld = 1'b1; byte_dat = {7'h31, 1'b1};
    @(negedge clk) byte_vld = 1'b0;
    check_eq("R11 late byte no match", match_pulse, 0);
    check_eq("R11 rw untouched", rw_bit, 0);

    // sweep of every mask setting against perturbed addresses, both modes
    for (int mk = 0; mk < 32; mk++) begin
      for (int k = 0; k < 8; k++) begin
        logic [9:0] flip;
        logic [7:0] b0, b1;
        bit m10;
        m10 = k[0];
        mask_bits = mk[4:0];
        gc_en = $urandom_range(0, 1);
        own_addr = 10'($urandom);
        case ($urandom_range(0, 3))
          0: flip = '0;
          1: flip = 10'(1) << $urandom_range(0, 9);
          2: flip = (10'(1) << $urandom_range(0, 9)) | (10'(1) << $urandom_range(0, 9));
          default: flip = 10'($urandom) & 10'h03F;
        endcase
        if (!m10) begin
          b0 = {own_addr[6:0] ^ flip[6:0], 1'($urandom)};
          b1 = 8'h00;
        end else begin
          b0 = {5'b11110, own_addr[9:8] ^ flip[9:8], 1'($urandom)};
          b1 = own_addr[7:0] ^ flip[7:0];
        end
        run_frame(m10, b0, b1, m10 ? "R6 sweep 10b" : "R3 sweep 7b");
      end
    end

    @(negedge clk);
    check_eq("R1 total pulse count", seen_pulses, exp_pulses);
    finish_run();
  end
endmodule